// File: doc/BRIEF.md
# Maskable Host Interrupt Request Generator

This block merges four board-level conditions into a single interrupt request for a host processor. The conditions are: a link byte waiting to be read by the host, a link ready to accept a byte from the host, a board error, and completion of a DMA transfer. A write-only mask register has one bit per condition, and a set bit lets that condition raise the request. All conditions share the same request, and host software works out the cause by reading status elsewhere.

The three link and error conditions are levels, so they raise the request only while they are present. DMA completion arrives as a falling edge on an active-low done signal. It is caught in a sticky latch that stays set until software clears its mask bit. While the whole mask is zero the block releases the request line entirely (no output enable). Once any mask bit is set, the line selected by a routing input is driven: low when idle and high when an unmasked condition is present.

Top module: `hostirq_gen`

## Requirements
- R1: The mask register is written only on a cycle with `wr_stb` high and takes effect from the following cycle. `wr_data[3]` enables link-input-ready, `wr_data[2]` link-output-ready, `wr_data[1]` error and `wr_data[0]` DMA done, where 1 means enabled. Bits above bit 3 have no effect.
- R2: A synchronous reset clears the mask and the DMA latch, so after reset no line is driven.
- R3: While all four mask bits are 0, no line has its output enable set, whatever the conditions.
- R4: While any mask bit is 1, the selected line's output enable is 1 and its level is 0 when no enabled condition is present.
- R5: A level condition whose mask bit is 1 drives the selected line high in the same cycle it is present, and the line falls in the same cycle the condition goes away.
- R6: A level condition whose mask bit is 0 does not affect the line level.
- R7: A falling edge on `dma_done_n` while mask bit 0 is 1 sets the DMA latch one clock later. The line then stays high after `dma_done_n` returns high, for as long as mask bit 0 stays 1.
- R8: Writing mask bit 0 as 0 clears the DMA latch. Writing it back to 1 does not raise the line again until a new falling edge on `dma_done_n`.
- R9: `line_sel` = 0 routes the request to line 0 (`irq_oe[0]`/`irq_lvl[0]`) and 1 routes it to line 1. The unselected line never has its output enable set.
- R10: All enabled conditions are ORed onto the one selected line.
- R11: A falling edge on `dma_done_n` that arrives while mask bit 0 is 0 is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Mask register write strobe |
| wr_data | input | 8 | Mask write data (bits 3..0 used) |
| line_sel | input | 1 | Request line routing select |
| lnk_in_rdy | input | 1 | Link has a byte for the host (level) |
| lnk_out_rdy | input | 1 | Link can accept a byte (level) |
| brd_err | input | 1 | Board error (level) |
| dma_done_n | input | 1 | DMA done, active low; falling edge marks completion |
| irq_lvl | output | 2 | Level driven on each request line |
| irq_oe | output | 2 | Output enable of each request line |

## Verification
The bench builds the block with its default eight-bit write bus and two request lines. This makes the product of all 16 mask values, all 8 level-condition patterns and both routing choices small enough to sweep completely, with the expected enable and level computed from the mask arithmetic. Directed sequences then exercise the DMA latch: setting it, holding it, clearing it through the mask, re-enabling it without a new edge, and ignoring an edge while masked. They also cover the ignored upper write bits, writes with the strobe low, and a reset applied while the latch is set.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
  localparam int EVT_W   = 4;
  localparam int B_INRDY = 3;
  localparam int B_OUTRDY = 2;
  localparam int B_ERR   = 1;
  localparam int B_DMA   = 0;

  typedef logic [EVT_W-1:0] evt_vec_t;

  function automatic evt_vec_t pack_events(input logic in_rdy, input logic out_rdy,
                                           input logic err, input logic dma_lat);
    evt_vec_t v;
    v = '0;
    v[B_INRDY]  = in_rdy;
    v[B_OUTRDY] = out_rdy;
    v[B_ERR]    = err;
    v[B_DMA]    = dma_lat;
    return v;
  endfunction

  function automatic logic pending(input evt_vec_t mask, input evt_vec_t evts);
    return |(mask & evts);
  endfunction
endpackage

// File: rtl/hostirq_mask_reg.sv
module hostirq_mask_reg
  import hostirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output evt_vec_t          mask_q
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:EVT_W];

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (wr_stb) mask_q <= wr_data[EVT_W-1:0];
  end

  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(mask_q));
endmodule

// File: rtl/hostirq_dma_latch.sv
module hostirq_dma_latch (
  input  logic clk,
  input  logic rst,
  input  logic dma_done_n,
  input  logic keep,
  output logic dma_fall,
  output logic dma_lat
);
  logic done_prev;

  assign dma_fall = done_prev & ~dma_done_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_prev <= 1'b1;
      dma_lat   <= 1'b0;
    end else begin
      done_prev <= dma_done_n;
      dma_lat   <= keep & (dma_lat | dma_fall);
    end
  end

  // R8
  dma_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !keep |=> !dma_lat);
  // R7
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_lat && keep) |=> dma_lat);
  // R11
  dma_noset_chk: assert property (@(posedge clk) disable iff (rst)
    (!dma_lat && !dma_fall) |=> !dma_lat);
endmodule

// File: rtl/hostirq_line_steer.sv
module hostirq_line_steer #(
  parameter int LINE_CNT = 2,
  localparam int SEL_W = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                drive_on,
  input  logic                req,
  input  logic [SEL_W-1:0]    sel,
  output logic [LINE_CNT-1:0] oe,
  output logic [LINE_CNT-1:0] lvl
);
  for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
    assign oe[i]  = drive_on && (sel == SEL_W'(i));
    assign lvl[i] = oe[i] & req;
  end

  // R9
  oe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe));
  // R3
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_on |-> (oe == '0));
endmodule

// File: rtl/hostirq_gen.sv
module hostirq_gen
  import hostirq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LINE_CNT = 2,
  localparam int SEL_W = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [SEL_W-1:0]    line_sel,
  input  logic                lnk_in_rdy,
  input  logic                lnk_out_rdy,
  input  logic                brd_err,
  input  logic                dma_done_n,
  output logic [LINE_CNT-1:0] irq_lvl,
  output logic [LINE_CNT-1:0] irq_oe
);
  evt_vec_t mask_q;
  evt_vec_t evts;
  logic     dma_fall;
  logic     dma_lat;
  logic     drive_on;
  logic     req;

  hostirq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .mask_q(mask_q)
  );

  hostirq_dma_latch u_dma (
    .clk(clk), .rst(rst), .dma_done_n(dma_done_n), .keep(mask_q[B_DMA]),
    .dma_fall(dma_fall), .dma_lat(dma_lat)
  );

  assign evts     = pack_events(lnk_in_rdy, lnk_out_rdy, brd_err, dma_lat);
  assign drive_on = |mask_q;
  assign req      = pending(mask_q, evts);

  hostirq_line_steer #(.LINE_CNT(LINE_CNT)) u_steer (
    .clk(clk), .rst(rst), .drive_on(drive_on), .req(req), .sel(line_sel),
    .oe(irq_oe), .lvl(irq_lvl)
  );

  // R2
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (irq_oe == '0));
  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q[B_ERR] && brd_err) |-> (irq_lvl == irq_oe));
endmodule

// File: tb/test_hostirq_gen.sv
module test_hostirq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       line_sel = 1'b0;
  logic       lnk_in_rdy = 1'b0, lnk_out_rdy = 1'b0, brd_err = 1'b0;
  logic       dma_done_n = 1'b1;
  logic [1:0] irq_lvl, irq_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostirq_gen i_hostirq_gen (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .line_sel(line_sel), .lnk_in_rdy(lnk_in_rdy), .lnk_out_rdy(lnk_out_rdy),
    .brd_err(brd_err), .dma_done_n(dma_done_n),
    .irq_lvl(irq_lvl), .irq_oe(irq_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] oe_of(input logic [3:0] m, input logic s);
    return (m != 4'd0) ? (2'b01 << s) : 2'b00;
  endfunction

  task automatic expect_out(input string tag, input logic [1:0] oe_e, input logic req_e);
    logic [1:0] lvl_e;
    #1;
    lvl_e = oe_e & {2{req_e}};
    checks++;
    if (irq_oe !== oe_e || irq_lvl !== lvl_e) begin
      errors++;
      $display("FAIL %s: oe=%b lvl=%b expected oe=%b lvl=%b", tag, irq_oe, irq_lvl, oe_e, lvl_e);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0; wr_data = 8'h00;
  endtask

  task automatic dma_pulse();
    @(negedge clk); dma_done_n = 1'b0;
    @(negedge clk); dma_done_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state with conditions active
    lnk_in_rdy = 1; brd_err = 1;
    expect_out("R2 in reset", 2'b00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R2 after reset", 2'b00, 1'b0);
    lnk_in_rdy = 0; brd_err = 0;

    // Sweep: R1 R3 R4 R5 R6 R9 R10
    for (int m = 0; m < 16; m++) begin
      wr(8'(m));
      for (int s = 0; s < 2; s++) begin
        for (int e = 0; e < 8; e++) begin
          @(negedge clk);
          line_sel = s[0];
          lnk_in_rdy = e[2]; lnk_out_rdy = e[1]; brd_err = e[0];
          expect_out("R1_R3_R4_R5_R6_R9_R10 sweep", oe_of(4'(m), s[0]),
                     (m[3] & e[2]) | (m[2] & e[1]) | (m[1] & e[0]));
        end
      end
    end
    @(negedge clk);
    lnk_in_rdy = 0; lnk_out_rdy = 0; brd_err = 0; line_sel = 0;

    // R7 latch sets and holds
    wr(8'h01);
    expect_out("R4 idle low", 2'b01, 1'b0);
    dma_pulse();
    expect_out("R7 latched", 2'b01, 1'b1);
    repeat (5) @(negedge clk);
    expect_out("R7 held", 2'b01, 1'b1);
    line_sel = 1;
    expect_out("R9 latched request moves line", 2'b10, 1'b1);
    line_sel = 0;

    // R8 clear then re-enable without new edge
    wr(8'h02);
    @(negedge clk);
    expect_out("R8 cleared by mask", 2'b01, 1'b0);
    wr(8'h01);
    @(negedge clk);
    expect_out("R8 no reassert", 2'b01, 1'b0);
    dma_pulse();
    expect_out("R8 new edge reasserts", 2'b01, 1'b1);
    wr(8'h00);
    expect_out("R3 all masked", 2'b00, 1'b0);
    wr(8'h01);
    @(negedge clk);
    expect_out("R8 after full clear", 2'b01, 1'b0);

    // R11 edge while masked
    wr(8'h04);
    dma_pulse();
    wr(8'h01);
    @(negedge clk);
    expect_out("R11 masked edge forgotten", 2'b01, 1'b0);

    // R1 upper bits and strobe
    wr(8'hF0);
    expect_out("R1 upper bits ignored", 2'b00, 1'b0);
    @(negedge clk); wr_data = 8'h0F;
    @(negedge clk); wr_data = 8'h00;
    expect_out("R1 no strobe no write", 2'b00, 1'b0);

    // R2 reset clears latch
    wr(8'h01);
    dma_pulse();
    expect_out("R7 set before reset", 2'b01, 1'b1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    expect_out("R2 reset releases", 2'b00, 1'b0);
    wr(8'h01);
    @(negedge clk);
    expect_out("R2 latch cleared by reset", 2'b01, 1'b0);

    // R10 DMA plus level together, drop level keeps DMA
    wr(8'h09);
    dma_pulse();
    lnk_in_rdy = 1;
    expect_out("R10 both", 2'b01, 1'b1);
    @(negedge clk); lnk_in_rdy = 0;
    expect_out("R10 dma remains", 2'b01, 1'b1);
    wr(8'h08);
    @(negedge clk);
    expect_out("R8 clear with level masked on", 2'b01, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule